// File: doc/BRIEF.md
# Video Memory Access Port

This block is the processor-side window into video memory. Software first writes a 14-bit video address as two bytes through one register: the high byte first, then the low byte. It then moves data through a second register. Each data access steps the address by 1 or by 32, and the address wraps inside the 14-bit space. A horizontal/vertical scroll register pair uses the same write-phase toggle as the address register. Reading the status register returns that toggle to its first phase, so software can restart a two-write sequence from a known point.

Data reads are pipelined through a one-byte read buffer. A read returns the byte fetched by the previous read, and the block then refills the buffer from the address just used. Addresses at or above the palette base are the exception: there the freshly fetched byte is returned directly. The memory behind the port has synchronous reads with one cycle of latency. While a refill is in flight the block raises `busy` and ignores all register accesses.

Top module: `vmap_port`

## Requirements
- R1: After reset, `mem_addr`, `rd_data`, `scroll_h` and `scroll_v` are zero, and `busy` and `mem_we` are low.
- R2: `reg_sel` value 2 selects the address register. The first write (toggle clear) stages `wr_data[5:0]` as the high six address bits and leaves `mem_addr` unchanged. The second write sets the address to {staged bits, `wr_data`}, so any value above 0x3FFF is reduced modulo 0x4000. Each address write flips the toggle.
- R3: `reg_sel` value 1 selects the scroll register and flips the same toggle. With the toggle clear, a write loads `scroll_h`; with it set, the write loads `scroll_v`. A scroll write followed by an address write makes the address write act as the second (low-byte) write.
- R4: A read with `reg_sel` value 0 (status) clears the toggle. The next address write is then treated as a first write.
- R5: A write with `reg_sel` value 3 (data) drives `mem_we` high in that same cycle, with `mem_addr` at the current address and `mem_wdata` equal to `wr_data`. The address then advances.
- R6: Every accepted data read or write advances the address by 1, or by 32 when `step_wide` is high. The result wraps modulo 0x4000 (0x3FFF+1 gives 0x0000; 0x3FF0+32 gives 0x0010).
- R7: A data read at an address below 0x3F00 returns the buffered byte from the previous read (zero after reset). The buffer is then refilled with the memory byte at the address read.
- R8: A data read at an address of 0x3F00 or higher returns the memory byte at that address once `busy` falls. The buffer is also refilled with that byte.
- R9: A data read holds `busy` high for two cycles. While `busy` is high, every register read and write is ignored and `mem_we` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register select: 0 status, 1 scroll, 2 address, 3 data |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| step_wide | input | 1 | Address step of 32 when high, 1 when low |
| mem_rdata | input | 8 | Memory read data, one cycle after the address |
| mem_addr | output | 14 | Video memory address |
| mem_we | output | 1 | Video memory write strobe |
| mem_wdata | output | 8 | Video memory write data |
| rd_data | output | 8 | Data returned by data-register reads |
| busy | output | 1 | Buffer refill in progress; accesses ignored |
| scroll_h | output | 8 | Horizontal scroll value |
| scroll_v | output | 8 | Vertical scroll value |

## Verification
The bench builds the port with its defaults: a 14-bit address, 8-bit data, a wide step of 32 and a palette base of 0x3F00. With these values a single two-byte load reaches the top address 0x3FFF, so the bench can test the +1 wrap and the +32 wrap from 0x3FF0 without long walks. The palette boundary sits in the same upper page, so buffered reads and direct reads are both exercised against one memory model. A high byte of 0xFF checks that the surplus upper bits are dropped on a load.

// File: rtl/vmap_pkg.sv
package vmap_pkg;

  // Register select codes seen on reg_sel
  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_SCROLL = 2'd1,
    SEL_ADDR   = 2'd2,
    SEL_DATA   = 2'd3
  } vmap_sel_e;

  // Read-buffer refill sequence
  typedef enum logic [1:0] {
    FILL_IDLE    = 2'd0,
    FILL_ISSUE   = 2'd1,
    FILL_CAPTURE = 2'd2
  } vmap_fill_e;

endpackage

// File: rtl/vmap_phase.sv
// Shared write-phase toggle, scroll pair and staged high address bits.
module vmap_phase #(
  parameter int DATA_W = 8,
  parameter int HI_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_status_rd,
  input  logic              ev_scroll_wr,
  input  logic              ev_addr_wr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_phase,
  output logic              load_go,
  output logic [HI_W-1:0]   hi_stage,
  output logic [DATA_W-1:0] scroll_h,
  output logic [DATA_W-1:0] scroll_v
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_phase <= 1'b0;
      hi_stage <= '0;
      scroll_h <= '0;
      scroll_v <= '0;
    end else begin
      if (ev_status_rd)
        wr_phase <= 1'b0;
      else if (ev_scroll_wr || ev_addr_wr)
        wr_phase <= ~wr_phase;

      if (ev_scroll_wr && !wr_phase) scroll_h <= wr_data;
      if (ev_scroll_wr &&  wr_phase) scroll_v <= wr_data;
      if (ev_addr_wr   && !wr_phase) hi_stage <= wr_data[HI_W-1:0];
    end
  end

  // Second address write commits the full address
  assign load_go = ev_addr_wr & wr_phase;

endmodule

// File: rtl/vmap_addr_ctr.sv
// Current video address: two-byte load and wrapping auto-step.
module vmap_addr_ctr #(
  parameter int ADDR_W    = 14,
  parameter int DATA_W    = 8,
  parameter int WIDE_STEP = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_go,
  input  logic [ADDR_W-DATA_W-1:0] hi_stage,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     step_go,
  input  logic                     step_wide,
  output logic [ADDR_W-1:0]        cur_addr
);

  localparam int HI_W = ADDR_W - DATA_W;
  localparam logic [ADDR_W:0] STEP_ONE  = (ADDR_W+1)'(1);
  localparam logic [ADDR_W:0] STEP_WIDE = (ADDR_W+1)'(WIDE_STEP);

  // Step with wrap: the carry out of the top bit is discarded
  function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] a,
                                                  input logic wide);
    logic [ADDR_W:0] sum;
    sum = {1'b0, a} + (wide ? STEP_WIDE : STEP_ONE);
    return sum[ADDR_W-1:0];
  endfunction

  // Join staged high bits with the low byte of the second write
  function automatic logic [ADDR_W-1:0] join_addr(input logic [HI_W-1:0] hi,
                                                  input logic [DATA_W-1:0] lo);
    return {hi, lo};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cur_addr <= '0;
    else if (load_go)
      cur_addr <= join_addr(hi_stage, wr_data);
    else if (step_go)
      cur_addr <= next_addr(cur_addr, step_wide);
  end

endmodule

// File: rtl/vmap_rdbuf.sv
// Read buffer with palette bypass; two-cycle refill from synchronous memory.
module vmap_rdbuf #(
  parameter int ADDR_W   = 14,
  parameter int DATA_W   = 8,
  parameter int PAL_BASE = 'h3F00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_data_rd,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] buf_q,
  output logic              fill_done,
  output logic              fill_pal
);
  import vmap_pkg::*;

  localparam logic [ADDR_W-1:0] PAL_A = ADDR_W'(PAL_BASE);

  function automatic logic in_palette(input logic [ADDR_W-1:0] a);
    return a >= PAL_A;
  endfunction

  vmap_fill_e st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= FILL_IDLE;
      fetch_addr <= '0;
      fill_pal   <= 1'b0;
      rd_data    <= '0;
      buf_q      <= '0;
    end else begin
      unique case (st)
        FILL_IDLE: begin
          if (ev_data_rd) begin
            fetch_addr <= cur_addr;
            fill_pal   <= in_palette(cur_addr);
            if (!in_palette(cur_addr)) rd_data <= buf_q;
            st <= FILL_ISSUE;
          end
        end
        FILL_ISSUE:   st <= FILL_CAPTURE;
        FILL_CAPTURE: begin
          buf_q <= mem_rdata;
          if (fill_pal) rd_data <= mem_rdata;
          st <= FILL_IDLE;
        end
        default:      st <= FILL_IDLE;
      endcase
    end
  end

  assign busy      = (st != FILL_IDLE);
  assign fill_done = (st == FILL_CAPTURE);

endmodule

// File: rtl/vmap_port.sv
// Top: register decode, memory address mux and write path.
module vmap_port #(
  parameter int ADDR_W    = 14,
  parameter int DATA_W    = 8,
  parameter int WIDE_STEP = 32,
  parameter int PAL_BASE  = 'h3F00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_sel,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              step_wide,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic [DATA_W-1:0] scroll_h,
  output logic [DATA_W-1:0] scroll_v
);
  import vmap_pkg::*;

  localparam int HI_W = ADDR_W - DATA_W;

  // Named internal events
  logic              ev_status_rd, ev_scroll_wr, ev_addr_wr, ev_data_wr, ev_data_rd;
  logic              wr_phase, load_go, fill_done, fill_pal;
  logic [HI_W-1:0]   hi_stage;
  logic [ADDR_W-1:0] cur_addr, fetch_addr;
  logic [DATA_W-1:0] buf_q;

  assign ev_status_rd = rd_en & ~busy & (reg_sel == SEL_STATUS);
  assign ev_scroll_wr = wr_en & ~busy & (reg_sel == SEL_SCROLL);
  assign ev_addr_wr   = wr_en & ~busy & (reg_sel == SEL_ADDR);
  assign ev_data_wr   = wr_en & ~busy & (reg_sel == SEL_DATA);
  assign ev_data_rd   = rd_en & ~wr_en & ~busy & (reg_sel == SEL_DATA);

  vmap_phase #(.DATA_W(DATA_W), .HI_W(HI_W)) u_phase (
    .clk(clk), .rst_n(rst_n),
    .ev_status_rd(ev_status_rd), .ev_scroll_wr(ev_scroll_wr), .ev_addr_wr(ev_addr_wr),
    .wr_data(wr_data), .wr_phase(wr_phase), .load_go(load_go), .hi_stage(hi_stage),
    .scroll_h(scroll_h), .scroll_v(scroll_v)
  );

  vmap_addr_ctr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIDE_STEP(WIDE_STEP)) u_addr (
    .clk(clk), .rst_n(rst_n), .load_go(load_go), .hi_stage(hi_stage),
    .wr_data(wr_data), .step_go(ev_data_wr | ev_data_rd), .step_wide(step_wide),
    .cur_addr(cur_addr)
  );

  vmap_rdbuf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAL_BASE(PAL_BASE)) u_rdbuf (
    .clk(clk), .rst_n(rst_n), .ev_data_rd(ev_data_rd), .cur_addr(cur_addr),
    .mem_rdata(mem_rdata), .busy(busy), .fetch_addr(fetch_addr), .rd_data(rd_data),
    .buf_q(buf_q), .fill_done(fill_done), .fill_pal(fill_pal)
  );

  // During a refill the memory sees the address that was read
  assign mem_addr  = busy ? fetch_addr : cur_addr;
  assign mem_we    = ev_data_wr;
  assign mem_wdata = wr_data;

endmodule

// File: rtl/vmap_port_chk.sv
// Checker for vmap_port, attached by bind below.
module vmap_port_chk #(
  parameter int ADDR_W    = 14,
  parameter int DATA_W    = 8,
  parameter int WIDE_STEP = 32,
  parameter int PAL_BASE  = 'h3F00
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [ADDR_W-1:0]        mem_addr,
  input logic                     mem_we,
  input logic [DATA_W-1:0]        mem_rdata,
  input logic [DATA_W-1:0]        wr_data,
  input logic [DATA_W-1:0]        rd_data,
  input logic                     busy,
  input logic                     step_wide,
  input logic                     wr_phase,
  input logic [ADDR_W-DATA_W-1:0] hi_stage,
  input logic [DATA_W-1:0]        buf_q,
  input logic                     ev_status_rd,
  input logic                     ev_scroll_wr,
  input logic                     ev_addr_wr,
  input logic                     ev_data_rd,
  input logic                     fill_done,
  input logic                     fill_pal,
  input logic [DATA_W-1:0]        scroll_h,
  input logic [DATA_W-1:0]        scroll_v
);

  localparam logic [ADDR_W-1:0] PAL_A = ADDR_W'(PAL_BASE);

  assert_second_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_addr_wr && wr_phase |=> mem_addr == {$past(hi_stage), $past(wr_data)});

  assert_first_load_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_addr_wr && !wr_phase |=> $stable(mem_addr));

  assert_scroll_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_scroll_wr && !wr_phase |=> scroll_h == $past(wr_data) && $stable(scroll_v));

  assert_status_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_status_rd |=> !wr_phase);

  assert_write_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> mem_addr == ADDR_W'($past(mem_addr) + ($past(step_wide) ? WIDE_STEP : 1)));

  assert_buffered_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_data_rd && (mem_addr < PAL_A) |=> rd_data == $past(buf_q));

  assert_palette_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done && fill_pal |=> rd_data == $past(mem_rdata) && buf_q == $past(mem_rdata));

  assert_busy_raise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_data_rd |=> busy);

  assert_no_write_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !mem_we);

endmodule

bind vmap_port vmap_port_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIDE_STEP(WIDE_STEP), .PAL_BASE(PAL_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_we(mem_we),
  .mem_rdata(mem_rdata), .wr_data(wr_data), .rd_data(rd_data), .busy(busy),
  .step_wide(step_wide), .wr_phase(wr_phase), .hi_stage(hi_stage), .buf_q(buf_q),
  .ev_status_rd(ev_status_rd), .ev_scroll_wr(ev_scroll_wr), .ev_addr_wr(ev_addr_wr),
  .ev_data_rd(ev_data_rd), .fill_done(fill_done), .fill_pal(fill_pal),
  .scroll_h(scroll_h), .scroll_v(scroll_v)
);

// File: tb/vmap_port_tb.sv
`timescale 1ns/1ps
module vmap_port_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_sel = '0;
  logic       rd_en = 1'b0, wr_en = 1'b0, step_wide = 1'b0;
  logic [7:0] wr_data = '0, mem_rdata = '0;
  logic [13:0] mem_addr;
  logic       mem_we, busy;
  logic [7:0] mem_wdata, rd_data, scroll_h, scroll_v;

  int n_run = 0, n_fail = 0, cyc = 0;

  always #2 clk = ~clk;  // 250 MHz

  vmap_port u_dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .step_wide(step_wide), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .rd_data(rd_data),
    .busy(busy), .scroll_h(scroll_h), .scroll_v(scroll_v)
  );

  // Memory model: unwritten bytes read back a fixed pattern of the address
  logic [7:0] mem_store [logic [13:0]];
  function automatic logic [7:0] pat(input logic [13:0] a);
    return a[7:0] ^ {2'b00, a[13:8]};
  endfunction
  function automatic logic [7:0] mem_look(input logic [13:0] a);
    if (mem_store.exists(a)) return mem_store[a];
    return pat(a);
  endfunction
  always @(posedge clk) begin
    mem_rdata <= mem_look(mem_addr);
    if (mem_we) mem_store[mem_addr] = mem_wdata;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // One register access, then wait until the port is idle
  task automatic access(input bit rd, input logic [1:0] sel, input logic [7:0] d,
                        input bit wide);
    @(negedge clk);
    rd_en = rd; wr_en = !rd; reg_sel = sel; wr_data = d; step_wide = wide;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    while (busy) @(negedge clk);
  endtask

  typedef struct packed {
    logic       rd;
    logic [1:0] sel;
    logic [7:0] dat;
    logic       wide;
    logic [13:0] ax;
    logic       crd;
    logic [7:0] rx;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd2, 8'h21, 1'b0, 14'h0000, 1'b0, 8'h00, 4'd2},  // R2 first write holds
    '{1'b0, 2'd2, 8'h08, 1'b0, 14'h2108, 1'b0, 8'h00, 4'd2},  // R2 second write loads
    '{1'b1, 2'd3, 8'h00, 1'b0, 14'h2109, 1'b1, 8'h00, 4'd7},  // R7 empty buffer
    '{1'b1, 2'd3, 8'h00, 1'b0, 14'h210A, 1'b1, 8'h29, 4'd7},  // R7 previous fetch
    '{1'b1, 2'd3, 8'h00, 1'b1, 14'h212A, 1'b1, 8'h28, 4'd6},  // R6 step of 32
    '{1'b0, 2'd3, 8'h5A, 1'b0, 14'h212B, 1'b0, 8'h00, 4'd5},  // R5 write then +1
    '{1'b0, 2'd2, 8'h21, 1'b0, 14'h212B, 1'b0, 8'h00, 4'd2},
    '{1'b0, 2'd2, 8'h2A, 1'b0, 14'h212A, 1'b0, 8'h00, 4'd2},
    '{1'b1, 2'd3, 8'h00, 1'b0, 14'h212B, 1'b1, 8'h2B, 4'd7},  // R7 stale byte
    '{1'b1, 2'd3, 8'h00, 1'b0, 14'h212C, 1'b1, 8'h5A, 4'd5},  // R5 written byte seen
    '{1'b0, 2'd2, 8'h3F, 1'b0, 14'h212C, 1'b0, 8'h00, 4'd2},
    '{1'b0, 2'd2, 8'h10, 1'b0, 14'h3F10, 1'b0, 8'h00, 4'd2},
    '{1'b1, 2'd3, 8'h00, 1'b0, 14'h3F11, 1'b1, 8'h2F, 4'd8},  // R8 direct palette
    '{1'b0, 2'd2, 8'h3F, 1'b0, 14'h3F11, 1'b0, 8'h00, 4'd2},
    '{1'b0, 2'd2, 8'hFF, 1'b0, 14'h3FFF, 1'b0, 8'h00, 4'd2},
    '{1'b1, 2'd3, 8'h00, 1'b0, 14'h0000, 1'b1, 8'hC0, 4'd6},  // R6 wrap +1, R8
    '{1'b0, 2'd2, 8'hFF, 1'b0, 14'h0000, 1'b0, 8'h00, 4'd2},
    '{1'b0, 2'd2, 8'hF0, 1'b0, 14'h3FF0, 1'b0, 8'h00, 4'd2},  // R2 high bits dropped
    '{1'b0, 2'd3, 8'h11, 1'b1, 14'h0010, 1'b0, 8'h00, 4'd6}   // R6 wrap +32
  };

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(mem_addr == 0 && rd_data == 0 && !busy && !mem_we && scroll_h == 0 && scroll_v == 0,
        "R1", "reset state", {mem_addr, rd_data}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      access(v.rd, v.sel, v.dat, v.wide);
      chk(mem_addr == v.ax, $sformatf("R%0d", v.req), $sformatf("vec %0d addr", i),
          mem_addr, v.ax);
      if (v.crd)
        chk(rd_data == v.rx, $sformatf("R%0d", v.req), $sformatf("vec %0d rd_data", i),
            rd_data, v.rx);
    end

    // R3 scroll pair shares the toggle
    access(1'b0, 2'd1, 8'h44, 1'b0);
    access(1'b0, 2'd1, 8'h66, 1'b0);
    chk(scroll_h == 8'h44, "R3", "scroll_h", scroll_h, 8'h44);
    chk(scroll_v == 8'h66, "R3", "scroll_v", scroll_v, 8'h66);
    access(1'b0, 2'd1, 8'h77, 1'b0);
    access(1'b0, 2'd2, 8'h12, 1'b0);
    chk(mem_addr == 14'h3F12, "R3", "address after scroll write", mem_addr, 14'h3F12);
    chk(scroll_h == 8'h77, "R3", "scroll_h second pair", scroll_h, 8'h77);

    // R4 status read resynchronises the toggle
    access(1'b0, 2'd2, 8'h01, 1'b0);
    access(1'b1, 2'd0, 8'h00, 1'b0);
    access(1'b0, 2'd2, 8'h02, 1'b0);
    chk(mem_addr == 14'h3F12, "R4", "first write after status", mem_addr, 14'h3F12);
    access(1'b0, 2'd2, 8'h34, 1'b0);
    chk(mem_addr == 14'h0234, "R4", "address after status", mem_addr, 14'h0234);

    // R9 accesses during refill are ignored
    @(negedge clk);
    rd_en = 1'b1; wr_en = 1'b0; reg_sel = 2'd3; step_wide = 1'b0;
    @(negedge clk);
    rd_en = 1'b0;
    chk(busy == 1'b1, "R9", "busy after read", busy, 1);
    wr_en = 1'b1; wr_data = 8'h99;
    #0.1;
    chk(mem_we == 1'b0, "R9", "mem_we while busy", mem_we, 0);
    @(negedge clk);
    wr_en = 1'b0;
    chk(busy == 1'b1, "R9", "busy second cycle", busy, 1);
    while (busy) @(negedge clk);
    chk(mem_addr == 14'h0235, "R9", "address after ignored write", mem_addr, 14'h0235);
    chk(rd_data == 8'hC0, "R7", "buffer kept across writes", rd_data, 8'hC0);
    access(1'b1, 2'd3, 8'h00, 1'b0);
    chk(rd_data == 8'h36, "R9", "ignored write left memory", rd_data, 8'h36);

    // R5 write port in the cycle of the write
    @(negedge clk);
    wr_en = 1'b1; reg_sel = 2'd3; wr_data = 8'hA5; step_wide = 1'b0;
    #0.1;
    chk(mem_we && mem_addr == 14'h0236 && mem_wdata == 8'hA5, "R5", "write port",
        {mem_we, mem_addr, mem_wdata}, {1'b1, 14'h0236, 8'hA5});
    @(negedge clk);
    wr_en = 1'b0;
    chk(mem_addr == 14'h0237, "R5", "address after write", mem_addr, 14'h0237);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule